// File: doc/BRIEF.md
# Clock Branch Gate Controller

This block controls one branch of a clock tree, the part of the tree that feeds a single downstream block. The branch runs when software sets a local enable bit, or when an external agent raises a vote line that software has allowed through a mask. It does not switch at once. The request passes through a chain of flops clocked by the free-running input clock, which stands in for the time a real branch takes to start or stop. Only the output of that chain drives the gate enable.

Software learns the branch state from a read-only "clock off" flag in the control word. The flag stays 1 until the delayed enable is actually high. A driver sets the enable, or arranges a vote, and then polls this flag until it reads 0. A driver that gives up after a bounded number of polls treats the branch as failed.

The same register window holds two more controls:
- a block-reset bit, which holds the downstream reset output high while it is set;
- a subsystem-reset hold bit, which comes out of reset set and releases its output when software clears it.

Top module: `clk_branch_gate`

## Requirements
- R1: After rst_ni is released:
  - the control word (address 0) reads 0x8000_0000, meaning off flag 1 and enable 0;
  - the vote mask (address 1) and the block-reset word (address 2) read 0;
  - the misc word (address 3) reads 1;
  - clk_en_o and blk_rst_o are 0 and subsys_rst_o is 1.
- R2: In the control word, bit 0 is a read/write enable. Bit DATA_W-1 is a read-only off flag that reads as the inverse of clk_en_o. A write of any value to the off flag leaves the flag and clk_en_o unchanged. All other bits read 0.
- R3: The effective enable is the control enable bit OR any bit of vote_i whose matching bit is set in the vote mask. A vote_i bit with a clear mask bit has no effect on clk_en_o.
- R4: clk_en_o goes high on the SYNC_STAGES-th consecutive rising edge at which the effective enable is sampled high, and not before. For a control write this is SYNC_STAGES edges after the write edge.
- R5: clk_en_o goes low on the SYNC_STAGES-th consecutive rising edge at which the effective enable is sampled low, and not before.
- R6: Writing bit 0 of address 2 sets blk_rst_o to the written value from the next edge, and it holds until the next write. The bit reads back in bit 0.
- R7: Writing bit 0 of address 3 sets subsys_rst_o to the written value from the next edge. Writing 0 releases the subsystem reset. The bit reads back in bit 0.
- R8: rdata_o is a combinational function of addr_i and state. A read changes no state, so repeated reads return the same value.
- R9: The vote mask is read/write in bits NUM_VOTES-1:0 of address 1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| vote_i | input | NUM_VOTES | External vote lines |
| clk_en_o | output | 1 | Delayed branch gate enable |
| blk_rst_o | output | 1 | Downstream block reset, active high |
| subsys_rst_o | output | 1 | Subsystem reset hold, active high |

## Verification
The gate is driven on its own by:
- the direct enable;
- a masked vote line;
- a vote line whose mask bit is clear;
- the direct enable and a vote together, with one of them then removed.

This separates the OR-merge from the mask filter. The off flag is sampled one cycle before and on the cycle where the change is due, both when the branch turns on and when it turns off. This tells a correct chain length from one that is a stage short or long. Writes that set the read-only flag bit, or set every other bit, show that only bit 0 of the control word takes effect.

// File: rtl/cbg_pkg.sv
`timescale 1ns/1ps
package cbg_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    CBG_CTRL   = 2'd0,
    CBG_VOTE   = 2'd1,
    CBG_BLKRST = 2'd2,
    CBG_MISC   = 2'd3
  } cbg_addr_e;
endpackage

// File: rtl/cbg_enable_merge.sv
`timescale 1ns/1ps
module cbg_enable_merge #(
  parameter int NUM_VOTES = 4
) (
  input  logic                 en_i,
  input  logic [NUM_VOTES-1:0] vote_i,
  input  logic [NUM_VOTES-1:0] mask_i,
  output logic                 eff_o
);
  logic [NUM_VOTES-1:0] vote_pass;

  assign vote_pass = vote_i & mask_i;
  assign eff_o     = en_i | (|vote_pass);
endmodule

// File: rtl/cbg_sync_delay.sv
`timescale 1ns/1ps
module cbg_sync_delay #(
  parameter int STAGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[0] <= 1'b0;
        else         pipe_q[0] <= d_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[g] <= 1'b0;
        else         pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cbg_regs.sv
`timescale 1ns/1ps
module cbg_regs
  import cbg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_VOTES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 clk_on_i,
  output logic                 en_o,
  output logic [NUM_VOTES-1:0] mask_o,
  output logic                 blk_rst_o,
  output logic                 subsys_rst_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o         <= 1'b0;
      mask_o       <= '0;
      blk_rst_o    <= 1'b0;
      subsys_rst_o <= 1'b1;
    end else if (we_i) begin
      case (cbg_addr_e'(addr_i))
        CBG_CTRL:   en_o         <= wdata_i[0];
        CBG_VOTE:   mask_o       <= wdata_i[NUM_VOTES-1:0];
        CBG_BLKRST: blk_rst_o    <= wdata_i[0];
        CBG_MISC:   subsys_rst_o <= wdata_i[0];
        default:    ;
      endcase
    end
  end

  // status bit is derived, never stored
  always_comb begin
    rdata_o = '0;
    case (cbg_addr_e'(addr_i))
      CBG_CTRL: begin
        rdata_o[0]        = en_o;
        rdata_o[DATA_W-1] = ~clk_on_i;
      end
      CBG_VOTE:   rdata_o[NUM_VOTES-1:0] = mask_o;
      CBG_BLKRST: rdata_o[0] = blk_rst_o;
      CBG_MISC:   rdata_o[0] = subsys_rst_o;
      default:    ;
    endcase
  end
endmodule

// File: rtl/clk_branch_gate.sv
`timescale 1ns/1ps
module clk_branch_gate
  import cbg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_VOTES   = 4,
  parameter int SYNC_STAGES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_VOTES-1:0] vote_i,
  output logic                 clk_en_o,
  output logic                 blk_rst_o,
  output logic                 subsys_rst_o
);
  logic                 en;
  logic [NUM_VOTES-1:0] mask;
  logic                 eff_en;

  cbg_regs #(
    .DATA_W   (DATA_W),
    .NUM_VOTES(NUM_VOTES)
  ) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .clk_on_i    (clk_en_o),
    .en_o        (en),
    .mask_o      (mask),
    .blk_rst_o   (blk_rst_o),
    .subsys_rst_o(subsys_rst_o)
  );

  cbg_enable_merge #(
    .NUM_VOTES(NUM_VOTES)
  ) i_merge (
    .en_i  (en),
    .vote_i(vote_i),
    .mask_i(mask),
    .eff_o (eff_en)
  );

  // vote lines are asynchronous; the chain also synchronizes them
  cbg_sync_delay #(
    .STAGES(SYNC_STAGES)
  ) i_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (eff_en),
    .q_o   (clk_en_o)
  );
endmodule

// File: rtl/cbg_chk.sv
`timescale 1ns/1ps
module cbg_chk
  import cbg_pkg::*;
#(
  parameter int SYNC_STAGES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wdata0_i,
  input logic              status_i,
  input logic              eff_en_i,
  input logic              clk_en_i,
  input logic              blk_rst_i,
  input logic              subsys_rst_i
);
  localparam int CW = $clog2(SYNC_STAGES + 1);
  localparam logic [CW-1:0] CMAX = CW'(SYNC_STAGES);

  logic [CW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= !eff_en_i ? '0 : (hi_cnt == CMAX ? hi_cnt : hi_cnt + 1'b1);
      lo_cnt <=  eff_en_i ? '0 : (lo_cnt == CMAX ? lo_cnt : lo_cnt + 1'b1);
    end
  end

  // R4
  on_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt == CMAX |-> clk_en_i);

  // R5
  off_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_cnt == CMAX |-> !clk_en_i);

  // R2
  status_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(CBG_CTRL) |-> status_i == !clk_en_i);

  // R6
  blk_rst_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_W'(CBG_BLKRST) |=> blk_rst_i == $past(wdata0_i));

  // R7
  subsys_rst_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_W'(CBG_MISC) |=> subsys_rst_i == $past(wdata0_i));

  // R6
  blk_rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(CBG_BLKRST)) |=> $stable(blk_rst_i));
endmodule

bind clk_branch_gate cbg_chk #(
  .SYNC_STAGES(SYNC_STAGES)
) i_cbg_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata0_i    (wdata_i[0]),
  .status_i    (rdata_o[DATA_W-1]),
  .eff_en_i    (eff_en),
  .clk_en_i    (clk_en_o),
  .blk_rst_i   (blk_rst_o),
  .subsys_rst_i(subsys_rst_o)
);

// File: tb/test_clk_branch_gate.sv
`timescale 1ns/1ps
module test_clk_branch_gate;
  localparam int DW = 32;
  localparam int NV = 4;
  localparam int N  = 4;
  localparam logic [1:0] A_CTRL = 2'd0, A_VOTE = 2'd1, A_BLK = 2'd2, A_MISC = 2'd3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0;
  logic [1:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [NV-1:0] vote_i = '0;
  logic          clk_en_o, blk_rst_o, subsys_rst_o;

  int checks = 0;
  int fails  = 0;
  bit mon_busy = 1'b0;
  bit done = 1'b0;
  bit cur_blk = 1'b0;
  bit cur_sub = 1'b1;

  logic [1:0]    q_addr[$];
  logic [DW-1:0] q_rd[$];
  logic          q_en[$];
  string         q_tag[$];

  always #2.5 clk = ~clk;

  clk_branch_gate #(.DATA_W(DW), .NUM_VOTES(NV), .SYNC_STAGES(N)) i_clk_branch_gate (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .vote_i(vote_i), .clk_en_o(clk_en_o),
    .blk_rst_o(blk_rst_o), .subsys_rst_o(subsys_rst_o)
  );

  function automatic logic [DW-1:0] ctrl_word(bit en, bit on);
    logic [DW-1:0] w;
    w = '0;
    w[0] = en;
    w[DW-1] = ~on;
    return w;
  endfunction

  // monitor: pops expected items and compares at the ports
  initial forever begin
    logic [1:0] a;
    logic [DW-1:0] rd;
    logic en;
    string tag;
    wait (q_addr.size() > 0);
    mon_busy = 1'b1;
    a = q_addr.pop_front();
    rd = q_rd.pop_front();
    en = q_en.pop_front();
    tag = q_tag.pop_front();
    addr_i = a;
    #1;
    checks++;
    if (rdata_o !== rd || clk_en_o !== en || blk_rst_o !== cur_blk || subsys_rst_o !== cur_sub) begin
      fails++;
      $display("FAIL %s addr=%0d: rdata=%h clk_en=%b blk=%b sub=%b expected rdata=%h clk_en=%b blk=%b sub=%b",
               tag, a, rdata_o, clk_en_o, blk_rst_o, subsys_rst_o, rd, en, cur_blk, cur_sub);
    end
    mon_busy = 1'b0;
  end

  // driver side: push one expected item and wait until it is compared
  task automatic expect_item(string tag, logic [1:0] a, logic [DW-1:0] rd, logic en);
    q_addr.push_back(a);
    q_rd.push_back(rd);
    q_en.push_back(en);
    q_tag.push_back(tag);
    wait (q_addr.size() == 0);
    wait (!mon_busy);
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    we_i = 1'b1;
    addr_i = a;
    wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    expect_item("R1 ctrl", A_CTRL, ctrl_word(0, 0), 1'b0);
    expect_item("R1 vote", A_VOTE, '0, 1'b0);
    expect_item("R1 blk",  A_BLK,  '0, 1'b0);
    expect_item("R1 misc", A_MISC, 32'd1, 1'b0);

    // R4 direct enable latency
    wr(A_CTRL, 32'd1);
    idle(N-1);
    expect_item("R4 direct still off", A_CTRL, ctrl_word(1, 0), 1'b0);
    idle(1);
    expect_item("R4 direct on", A_CTRL, ctrl_word(1, 1), 1'b1);
    // R8 repeated reads, interleaved
    expect_item("R8 reread ctrl", A_CTRL, ctrl_word(1, 1), 1'b1);
    expect_item("R8 read misc", A_MISC, 32'd1, 1'b1);
    expect_item("R8 ctrl again", A_CTRL, ctrl_word(1, 1), 1'b1);

    // R2 writes to status bit and unused bits ignored
    wr(A_CTRL, 32'h8000_0001);
    idle(N+2);
    expect_item("R2 status write while on", A_CTRL, ctrl_word(1, 1), 1'b1);
    wr(A_CTRL, 32'hFFFF_FFFF);
    idle(2);
    expect_item("R2 all ones write", A_CTRL, ctrl_word(1, 1), 1'b1);

    // R5 disable latency
    wr(A_CTRL, 32'd0);
    idle(N-1);
    expect_item("R5 still on", A_CTRL, ctrl_word(0, 1), 1'b1);
    idle(1);
    expect_item("R5 off", A_CTRL, ctrl_word(0, 0), 1'b0);
    wr(A_CTRL, 32'h8000_0000);
    idle(N+2);
    expect_item("R2 status write while off", A_CTRL, ctrl_word(0, 0), 1'b0);

    // R9 mask read back; R3 unmasked vote has no effect
    wr(A_VOTE, 32'hFFFF_FFF4 & 32'h0000_0004);
    expect_item("R9 mask", A_VOTE, 32'd4, 1'b0);
    wr(A_VOTE, 32'hFFFF_FFFF);
    expect_item("R9 upper bits zero", A_VOTE, 32'h0000_000F, 1'b0);
    wr(A_VOTE, 32'd4);
    @(negedge clk); vote_i = 4'b0010;
    idle(N+3);
    expect_item("R3 unmasked vote", A_CTRL, ctrl_word(0, 0), 1'b0);

    // R4 vote path latency
    @(negedge clk); vote_i = 4'b0110;
    idle(N-1);
    expect_item("R4 vote still off", A_CTRL, ctrl_word(0, 0), 1'b0);
    idle(1);
    expect_item("R4 vote on", A_CTRL, ctrl_word(0, 1), 1'b1);
    // R5 vote withdrawn
    @(negedge clk); vote_i = 4'b0000;
    idle(N-1);
    expect_item("R5 vote still on", A_CTRL, ctrl_word(0, 1), 1'b1);
    idle(1);
    expect_item("R5 vote off", A_CTRL, ctrl_word(0, 0), 1'b0);

    // R3 OR of both sources
    wr(A_CTRL, 32'd1);
    @(negedge clk); vote_i = 4'b0100;
    idle(N+2);
    expect_item("R3 both on", A_CTRL, ctrl_word(1, 1), 1'b1);
    @(negedge clk); vote_i = 4'b0000;
    idle(N+2);
    expect_item("R3 enable keeps on", A_CTRL, ctrl_word(1, 1), 1'b1);
    @(negedge clk); vote_i = 4'b0100;
    wr(A_CTRL, 32'd0);
    idle(N+2);
    expect_item("R3 vote keeps on", A_CTRL, ctrl_word(0, 1), 1'b1);
    wr(A_VOTE, 32'd0);
    @(negedge clk); vote_i = 4'b1111;
    idle(N+2);
    expect_item("R3 mask cleared", A_CTRL, ctrl_word(0, 0), 1'b0);
    vote_i = '0;

    // R6 block reset
    wr(A_BLK, 32'd1);
    cur_blk = 1'b1;
    expect_item("R6 blk set", A_BLK, 32'd1, 1'b0);
    idle(3);
    expect_item("R6 blk held", A_BLK, 32'd1, 1'b0);
    wr(A_BLK, 32'd0);
    cur_blk = 1'b0;
    expect_item("R6 blk released", A_BLK, 32'd0, 1'b0);

    // R7 subsystem reset
    wr(A_MISC, 32'd0);
    cur_sub = 1'b0;
    expect_item("R7 sub released", A_MISC, 32'd0, 1'b0);
    wr(A_MISC, 32'd1);
    cur_sub = 1'b1;
    expect_item("R7 sub held", A_MISC, 32'd1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule